// File: doc/BRIEF.md
# Repeater False-Carrier Disconnect Monitor

This block sits beside the 100 Mb/s receive path of a repeater port. It sorts every receive carrier event into good or false and counts the false ones. It also decides when the receive path must be cut off from the MII and when it may be joined again. An event is false when its start delimiter was not received correctly. Decoding the start delimiter is done upstream. This block sees only a carrier-start pulse and a flag that qualifies that pulse.

The port is cut off in two cases: two false events arrive with no good frame end between them, or one false event runs for a long time. While the port is cut off, receive-valid toward the MII is held low. The port joins again after a good carrier event that runs long enough, or after a long unbroken window of idle symbols. Software sees two things: an 8-bit false-carrier count that clears when read, and a sticky flag that records a cut-off since the last read. The guard acts only when repeater mode and the enable bit are both set. The count is kept in 100M mode whether or not the guard is active.

Top module: `rpt_fc_guard`

## Requirements
- R1: When mode_100_i is 1, a crs_start_i pulse with ssd_ok_i=0 adds 1 to fc_cnt_o on the next cycle. A start with ssd_ok_i=1, or any start when mode_100_i is 0, leaves the count unchanged.
- R2: fc_cnt_o saturates at 255. Further false events leave it at 255.
- R3: A cnt_rd_i strobe sets fc_cnt_o to 0 on the next cycle, and fc_cnt_o shows the pre-read value in the strobe cycle. If a false event arrives in the same cycle as the strobe, the count restarts at 1.
- R4: With the guard active, a false start while an earlier false start has not been followed by good_end_i raises isolate_o on the next cycle. A good_end_i pulse between the two false starts prevents this.
- R5: With the guard active, a false event that is still open when its 480th counted bit tick arrives raises isolate_o on that clock edge. Ticks in the start cycle are not counted. After 479 counted ticks the port is still joined.
- R6: While isolated, a good event that is still open when its 480th counted bit tick arrives clears isolate_o on that clock edge.
- R7: While isolated, 27500 consecutive bit ticks with idle_i=1 clear isolate_o on the edge of the last tick. A cycle with idle_i=0 restarts the window.
- R8: The guard is active only when rpt_mode_i=1 and disc_en_i=1. If either is 0, isolate_o is 0 from the next cycle on and never rises.
- R9: disc_sticky_o rises together with isolate_o and is cleared by cnt_rd_i. If a strobe coincides with a new cut-off, the flag stays 1.
- R10: rx_dv_o equals rx_dv_i while joined and is 0 while isolated.
- R11: After reset, isolate_o, fc_cnt_o and disc_sticky_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One pulse per line bit time |
| crs_start_i | input | 1 | Carrier event begins |
| crs_end_i | input | 1 | Carrier event ends |
| ssd_ok_i | input | 1 | Start delimiter was correct, qualifies crs_start_i |
| good_end_i | input | 1 | Pulse for a frame that ended correctly |
| idle_i | input | 1 | Line carries idle symbols |
| rpt_mode_i | input | 1 | Repeater mode |
| mode_100_i | input | 1 | 100 Mb/s mode |
| disc_en_i | input | 1 | Enable bit for the disconnect function |
| cnt_rd_i | input | 1 | Read strobe for the counter register |
| rx_dv_i | input | 1 | Receive-valid from the framing logic |
| rx_dv_o | output | 1 | Receive-valid toward the MII, gated by isolation |
| isolate_o | output | 1 | Receive path is cut off |
| fc_cnt_o | output | 8 | False-carrier count |
| disc_sticky_o | output | 1 | A cut-off happened since the last read |

## Verification
Two pairs of functions can fall in the same clock cycle, and the bench provokes each pair directly. In the first pair, a counter read strobe lands in the cycle of a new false start. The bench expects the old count in that cycle and a count of 1 afterwards. In the second pair, the read strobe lands in the cycle of a cut-off caused by a repeated false start. The bench expects the sticky flag to stay set and isolate_o to rise. A random phase mixes starts, reads and mode changes, and compares the count against a bench model cycle by cycle.

// File: rtl/rfg_pkg.sv
package rfg_pkg;
  typedef enum logic {
    LINK_ON  = 1'b0,
    LINK_CUT = 1'b1
  } link_state_e;
endpackage

// File: rtl/rfg_evt_track.sv
module rfg_evt_track #(
  parameter int LONG_BT = 480,
  parameter int GOOD_BT = 480
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic crs_start_i,
  input  logic crs_end_i,
  input  logic ssd_ok_i,
  output logic false_start_o,
  output logic long_false_o,
  output logic good_span_o
);
  localparam int SPAN_TOP = ((LONG_BT > GOOD_BT) ? LONG_BT : GOOD_BT) - 1;
  localparam int TMR_W    = $clog2(SPAN_TOP + 2);

  logic             in_evt_q;
  logic             false_q;
  logic [TMR_W-1:0] span_q;

  assign false_start_o = crs_start_i & ~ssd_ok_i;
  assign long_false_o  = in_evt_q & false_q & bit_tick_i & (span_q == TMR_W'(LONG_BT - 1));
  assign good_span_o   = in_evt_q & ~false_q & bit_tick_i & (span_q == TMR_W'(GOOD_BT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_evt_q <= 1'b0;
      false_q  <= 1'b0;
      span_q   <= '0;
    end else if (crs_start_i) begin
      in_evt_q <= 1'b1;
      false_q  <= ~ssd_ok_i;
      span_q   <= '0;
    end else if (crs_end_i) begin
      in_evt_q <= 1'b0;
      span_q   <= '0;
    end else if (in_evt_q && bit_tick_i && span_q != TMR_W'(SPAN_TOP)) begin
      span_q <= span_q + 1'b1;
    end
  end
endmodule

// File: rtl/rfg_idle_win.sv
module rfg_idle_win #(
  parameter int IDLE_BT = 27500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic idle_i,
  output logic idle_hit_o
);
  localparam int IDLE_W = $clog2(IDLE_BT + 1);
  localparam logic [IDLE_W-1:0] IDLE_TOP = IDLE_W'(IDLE_BT - 1);

  logic [IDLE_W-1:0] run_q;

  assign idle_hit_o = idle_i & bit_tick_i & (run_q == IDLE_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 run_q <= '0;
    else if (!idle_i)                            run_q <= '0;
    else if (bit_tick_i && run_q != IDLE_TOP)    run_q <= run_q + 1'b1;
  end
endmodule

// File: rtl/rfg_fc_count.sv
module rfg_fc_count #(
  parameter int CNT_W    = 8,
  parameter bit SATURATE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] bump;

  generate
    if (SATURATE) begin : g_sat
      assign bump = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    end else begin : g_wrap
      assign bump = cnt_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= inc_i ? CNT_W'(1) : '0;
    else if (inc_i) cnt_q <= bump;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rpt_fc_guard.sv
module rpt_fc_guard
  import rfg_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int LONG_BT = 480,
  parameter int GOOD_BT = 480,
  parameter int IDLE_BT = 27500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_tick_i,
  input  logic             crs_start_i,
  input  logic             crs_end_i,
  input  logic             ssd_ok_i,
  input  logic             good_end_i,
  input  logic             idle_i,
  input  logic             rpt_mode_i,
  input  logic             mode_100_i,
  input  logic             disc_en_i,
  input  logic             cnt_rd_i,
  input  logic             rx_dv_i,
  output logic             rx_dv_o,
  output logic             isolate_o,
  output logic [CNT_W-1:0] fc_cnt_o,
  output logic             disc_sticky_o
);
  link_state_e st_q;
  logic        streak_q;
  logic        sticky_q;
  logic        false_start, long_false, good_span, idle_hit;
  logic        guard_on, cut, mend;

  rfg_evt_track #(.LONG_BT(LONG_BT), .GOOD_BT(GOOD_BT)) u_evt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_tick_i   (bit_tick_i),
    .crs_start_i  (crs_start_i),
    .crs_end_i    (crs_end_i),
    .ssd_ok_i     (ssd_ok_i),
    .false_start_o(false_start),
    .long_false_o (long_false),
    .good_span_o  (good_span)
  );

  rfg_idle_win #(.IDLE_BT(IDLE_BT)) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_tick_i(bit_tick_i),
    .idle_i    (idle_i),
    .idle_hit_o(idle_hit)
  );

  rfg_fc_count #(.CNT_W(CNT_W), .SATURATE(1'b1)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (false_start & mode_100_i),
    .clr_i (cnt_rd_i),
    .cnt_o (fc_cnt_o)
  );

  assign guard_on = rpt_mode_i & disc_en_i;
  assign cut  = guard_on && (st_q == LINK_ON)  && ((false_start && streak_q) || long_false);
  assign mend = guard_on && (st_q == LINK_CUT) && (good_span || idle_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= LINK_ON;
      streak_q <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      if (!guard_on) st_q <= LINK_ON;
      else if (cut)  st_q <= LINK_CUT;
      else if (mend) st_q <= LINK_ON;

      // streak remembers an unanswered false start
      if (!guard_on || cut || mend) streak_q <= 1'b0;
      else if (false_start)         streak_q <= 1'b1;
      else if (good_end_i)          streak_q <= 1'b0;

      if (cut)           sticky_q <= 1'b1;
      else if (cnt_rd_i) sticky_q <= 1'b0;
    end
  end

  assign isolate_o     = (st_q == LINK_CUT);
  assign rx_dv_o       = rx_dv_i & ~isolate_o;
  assign disc_sticky_o = sticky_q;
endmodule

// File: rtl/rfg_guard_chk.sv
module rfg_guard_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             crs_start_i,
  input logic             ssd_ok_i,
  input logic             mode_100_i,
  input logic             rpt_mode_i,
  input logic             disc_en_i,
  input logic             cnt_rd_i,
  input logic             isolate_o,
  input logic [CNT_W-1:0] fc_cnt_o,
  input logic             disc_sticky_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_hold_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_rd_i && !(crs_start_i && !ssd_ok_i)) |=> $stable(fc_cnt_o));

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fc_cnt_o == CMAX && !cnt_rd_i) |=> fc_cnt_o == CMAX);

  p_read_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rd_i && !(crs_start_i && !ssd_ok_i && mode_100_i)) |=> fc_cnt_o == '0);

  p_guard_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rpt_mode_i && disc_en_i) |=> !isolate_o);

  p_sticky_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(isolate_o) |-> disc_sticky_o);
endmodule

bind rpt_fc_guard rfg_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .crs_start_i  (crs_start_i),
  .ssd_ok_i     (ssd_ok_i),
  .mode_100_i   (mode_100_i),
  .rpt_mode_i   (rpt_mode_i),
  .disc_en_i    (disc_en_i),
  .cnt_rd_i     (cnt_rd_i),
  .isolate_o    (isolate_o),
  .fc_cnt_o     (fc_cnt_o),
  .disc_sticky_o(disc_sticky_o)
);

// File: tb/rpt_fc_guard_tb.sv
module rpt_fc_guard_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, cs = 1'b0, ce = 1'b0, ok = 1'b0, gend = 1'b0, idle = 1'b0;
  logic rpt = 1'b0, m100 = 1'b1, en = 1'b1, rd = 1'b0, dv_i = 1'b0;
  logic dv_o, iso, sticky;
  logic [7:0] cnt;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rpt_fc_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .crs_start_i(cs), .crs_end_i(ce),
    .ssd_ok_i(ok), .good_end_i(gend), .idle_i(idle), .rpt_mode_i(rpt), .mode_100_i(m100),
    .disc_en_i(en), .cnt_rd_i(rd), .rx_dv_i(dv_i), .rx_dv_o(dv_o), .isolate_o(iso),
    .fc_cnt_o(cnt), .disc_sticky_o(sticky)
  );

  function automatic int next_cnt(int c, bit inc, bit clr);
    if (clr) return inc ? 1 : 0;
    if (inc) return (c == 255) ? 255 : c + 1;
    return c;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_evt(bit good);
    cs = 1'b1; ok = good; step(); cs = 1'b0;
  endtask

  task automatic end_evt();
    ce = 1'b1; step(); ce = 1'b0;
  endtask

  task automatic pulse_rd();
    rd = 1'b1; step(); rd = 1'b0;
  endtask

  task automatic pulse_gend();
    gend = 1'b1; step(); gend = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int exp_c;
    void'($urandom(32'd4711));
    step(3);
    // R11 reset state
    check("R11 isolate", iso, 0);
    check("R11 count", cnt, 0);
    check("R11 sticky", sticky, 0);
    rst_n = 1'b1;
    step();

    // R1 counting, guard inactive
    start_evt(0); end_evt(); start_evt(0); end_evt(); start_evt(0); end_evt();
    check("R1 three false", cnt, 3);
    start_evt(1); end_evt();
    check("R1 good start", cnt, 3);
    m100 = 1'b0; start_evt(0); end_evt(); m100 = 1'b1;
    check("R1 not 100M", cnt, 3);

    // R3 read clears, old value visible during strobe
    rd = 1'b1;
    check("R3 old value", cnt, 3);
    step(); rd = 1'b0;
    check("R3 cleared", cnt, 0);
    start_evt(0); start_evt(0);
    cs = 1'b1; ok = 1'b0; rd = 1'b1; step(); cs = 1'b0; rd = 1'b0;
    check("R3 read plus event", cnt, 1);
    end_evt();

    // R2 saturation
    for (int i = 0; i < 300; i++) start_evt(0);
    end_evt();
    check("R2 saturate", cnt, 255);
    pulse_rd();

    // R4 consecutive false starts, guard active
    rpt = 1'b1; en = 1'b1; step();
    start_evt(0); end_evt(); pulse_gend(); start_evt(0); end_evt();
    check("R4 good frame between", iso, 0);
    start_evt(0);
    check("R4 second false", iso, 1);
    check("R9 sticky on cut", sticky, 1);
    end_evt();
    dv_i = 1'b1; step();
    check("R10 dv blocked", dv_o, 0);

    // R6 reconnect on long good event
    start_evt(1); tick = 1'b1; step(479);
    check("R6 479 ticks", iso, 1);
    step();
    check("R6 480 ticks", iso, 0);
    tick = 1'b0; end_evt();
    check("R10 dv passes", dv_o, 1);
    dv_i = 1'b0;
    check("R9 sticky held", sticky, 1);
    pulse_rd();
    check("R9 cleared by read", sticky, 0);

    // R5 long false event
    pulse_gend();
    start_evt(0); tick = 1'b1; step(479);
    check("R5 479 ticks", iso, 0);
    step();
    check("R5 480 ticks", iso, 1);
    tick = 1'b0; end_evt();

    // R7 idle window, with restart
    tick = 1'b1; idle = 1'b1; step(20000);
    idle = 1'b0; step();
    idle = 1'b1; step(27499);
    check("R7 window restarted", iso, 1);
    step();
    check("R7 idle reconnect", iso, 0);
    idle = 1'b0; tick = 1'b0; step();

    // R9 read coinciding with a cut
    pulse_rd();
    check("R9 cleared", sticky, 0);
    start_evt(0); end_evt();
    cs = 1'b1; ok = 1'b0; rd = 1'b1; step(); cs = 1'b0; rd = 1'b0;
    check("R9 read at cut", sticky, 1);
    check("R4 cut at read", iso, 1);
    check("R3 count at read", cnt, 1);
    end_evt();

    // R8 guard disabled
    en = 1'b0; step();
    check("R8 enable low", iso, 0);
    start_evt(0); end_evt(); start_evt(0); end_evt();
    check("R8 no cut enable low", iso, 0);
    en = 1'b1; rpt = 1'b0;
    start_evt(0); end_evt(); start_evt(0); end_evt();
    check("R8 no cut repeater off", iso, 0);

    // Random counter phase (R1 R2 R3 R8)
    pulse_rd();
    exp_c = 0;
    for (int i = 0; i < 3000; i++) begin
      bit s, g, r, m;
      s = ($urandom % 3) == 0;
      g = $urandom % 2;
      r = ($urandom % 8) == 0;
      m = ($urandom % 4) != 0;
      cs = s; ok = g; rd = r; m100 = m;
      ce = !s && (($urandom % 4) == 0);
      gend = $urandom % 2;
      en = $urandom % 2;
      step();
      exp_c = next_cnt(exp_c, s && !g && m, r);
      check("R1 R3 random count", cnt, exp_c);
      check("R8 random isolate", iso, 0);
    end
    cs = 1'b0; rd = 1'b0; ce = 1'b0; gend = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule